// File: doc/BRIEF.md
# Low-Power Scan Pattern Source with Per-Bit Freeze Stage

This block is a pseudorandom stimulus source for scan-based self-test that also limits switching in the scan chains. An n-bit linear feedback shift register produces a new word on every shift cycle. Each bit of that word then passes through its own freeze stage before it reaches an XOR spreading network. Each stage is a clock-enabled flip-flop that either follows its generator bit or keeps the value it last captured. Each scan-chain input is the XOR of three distinct frozen-stage outputs. A chain whose three stages are all frozen therefore sees a constant value, and its shift activity stops.

A mask register selects which stages follow and which freeze, with one bit per stage. Software or a weighting circuit outside the block streams the next pattern's mask in one bit at a time through a serial fill register. A per-pattern reload strobe then copies the whole fill register into the mask in one step. This lets the mask for the next pattern be prepared while the current pattern shifts. A seed-load input restarts the generator from a chosen nonzero word.

Top module: `lp_prpg`

## Requirements
- R1: While `rst` is high on a clock edge, the design returns to its initial state: the generator holds the default seed 16'hACE1, the fill register is all zeros, the mask is all ones (every stage following), every freeze stage holds 0, and `chain_out` is all zeros.
- R2: On an edge with `seed_ld` high, the generator loads `seed_val`. A zero `seed_val` is replaced by the default seed. `seed_ld` takes priority over `shift_en`, and the generator word is never zero.
- R3: On an edge with `shift_en` high and `seed_ld` low, the generator word g becomes {g[W-2:0], ^(g & TAPS)}, with TAPS = 16'hB400. When both inputs are low, g does not change.
- R4: On an edge with `shift_en` high, every stage i whose mask bit is 1 captures generator bit i as it stood before that edge.
- R5: A stage whose mask bit is 0 keeps its value. A stage also keeps its value on any edge with `shift_en` low.
- R6: On every edge, `chain_out[c]` is registered as the XOR of stages c mod W, (c+S) mod W and (c+2S) mod W, where S = W/3. With the defaults, chain 0 uses stages 0, 5 and 10.
- R7: On an edge with `mask_shift` high, the fill register shifts left by one position. `mask_bit` enters at bit 0 and the top bit is discarded. The fill register does not change otherwise.
- R8: On an edge with `reload` high, the mask takes the whole fill register as it stood before that edge, including when a shift of the fill register happens on the same edge.
- R9: If all three stages that feed chain c have mask bit 0, `chain_out[c]` stays constant from the second edge after that mask takes effect, however many shift cycles pass.
- R10: An all-zero mask freezes every chain output while the generator keeps advancing. A later mask with ones starts the chains changing again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_ld | input | 1 | Load `seed_val` into the generator |
| seed_val | input | W | Generator seed (zero selects the default seed) |
| shift_en | input | 1 | Advance the generator and update the following stages |
| mask_bit | input | 1 | Serial bit for the fill register |
| mask_shift | input | 1 | Shift `mask_bit` into the fill register |
| reload | input | 1 | Per-pattern parallel copy of the fill register into the mask |
| chain_out | output | CH | Registered scan-chain input bits |

## Verification
On every cycle, the assertions check the following. A masked-off stage never changes. No stage and no generator bit moves without a shift or a seed load. The generator shifts its bits by one position, and its word never becomes zero. A reload moves the fill register into the mask. A chain whose three stages are all masked off stays constant two edges later. The bench's scenarios cover what the assertions cannot see at the ports. They compare every chain output against an independent generator and freeze model across free runs, zero and normal seeds, a reload that lands on the same edge as a fill shift, a partly frozen mask and a fully frozen mask.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  // Freeze-stage operating mode, taken straight from its mask bit.
  typedef enum logic {
    STAGE_FREEZE = 1'b0,
    STAGE_FOLLOW = 1'b1
  } stage_mode_e;

  // Stage index feeding input k (0..2) of chain c in a W-bit spreader.
  // The stride of W/3 keeps the three indices distinct for W >= 3.
  function automatic int unsigned spread_tap(input int unsigned c,
                                             input int unsigned k,
                                             input int unsigned w);
    return (c + k * (w / 3)) % w;
  endfunction

endpackage

// File: rtl/lpg_gen.sv
module lpg_gen #(
  parameter int         W        = 16,
  parameter logic [W-1:0] TAPS   = 16'hB400,
  parameter logic [W-1:0] DEF_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_ld,
  input  logic [W-1:0] seed_val,
  input  logic         step,
  output logic [W-1:0] word
);

  logic [W-1:0] word_q;
  logic         fb;

  assign fb   = ^(word_q & TAPS);
  assign word = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= DEF_SEED;
    end else if (seed_ld) begin
      word_q <= (seed_val == '0) ? DEF_SEED : seed_val;
    end else if (step) begin
      word_q <= {word_q[W-2:0], fb};
    end
  end

endmodule

// File: rtl/lpg_mask.sv
module lpg_mask #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_bit,
  input  logic         mask_shift,
  input  logic         reload,
  output logic [W-1:0] fill,
  output logic [W-1:0] mask
);

  logic [W-1:0] fill_q;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (mask_shift) begin
      fill_q <= {fill_q[W-2:0], mask_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (reload) begin
      mask_q <= fill_q;
    end
  end

  assign fill = fill_q;
  assign mask = mask_q;

endmodule

// File: rtl/lpg_freeze.sv
module lpg_freeze
  import lpg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] gen_word,
  output logic [W-1:0] stage
);

  for (genvar i = 0; i < W; i++) begin : g_stage
    stage_mode_e mode;
    logic        bit_q;

    assign mode = stage_mode_e'(mask[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= 1'b0;
      end else if (step && (mode == STAGE_FOLLOW)) begin
        bit_q <= gen_word[i];
      end
    end

    assign stage[i] = bit_q;
  end

endmodule

// File: rtl/lpg_spread.sv
module lpg_spread
  import lpg_pkg::*;
#(
  parameter int W  = 16,
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  stage,
  output logic [CH-1:0] chain
);

  for (genvar c = 0; c < CH; c++) begin : g_chain
    localparam int unsigned IA = spread_tap(c, 0, W);
    localparam int unsigned IB = spread_tap(c, 1, W);
    localparam int unsigned IC = spread_tap(c, 2, W);
    logic out_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q <= 1'b0;
      end else begin
        out_q <= stage[IA] ^ stage[IB] ^ stage[IC];
      end
    end

    assign chain[c] = out_q;
  end

endmodule

// File: rtl/lp_prpg.sv
module lp_prpg #(
  parameter int           W        = 16,
  parameter int           CH       = 8,
  parameter logic [W-1:0] TAPS     = 16'hB400,
  parameter logic [W-1:0] DEF_SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seed_ld,
  input  logic [W-1:0]  seed_val,
  input  logic          shift_en,
  input  logic          mask_bit,
  input  logic          mask_shift,
  input  logic          reload,
  output logic [CH-1:0] chain_out
);

  logic [W-1:0] gen_word;
  logic [W-1:0] fill_word;
  logic [W-1:0] mask_word;
  logic [W-1:0] stage_word;

  lpg_gen #(.W(W), .TAPS(TAPS), .DEF_SEED(DEF_SEED)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .seed_ld  (seed_ld),
    .seed_val (seed_val),
    .step     (shift_en),
    .word     (gen_word)
  );

  lpg_mask #(.W(W)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .mask_bit   (mask_bit),
    .mask_shift (mask_shift),
    .reload     (reload),
    .fill       (fill_word),
    .mask       (mask_word)
  );

  lpg_freeze #(.W(W)) u_freeze (
    .clk      (clk),
    .rst      (rst),
    .step     (shift_en),
    .mask     (mask_word),
    .gen_word (gen_word),
    .stage    (stage_word)
  );

  lpg_spread #(.W(W), .CH(CH)) u_spread (
    .clk   (clk),
    .rst   (rst),
    .stage (stage_word),
    .chain (chain_out)
  );

endmodule

// File: rtl/lpg_chk.sv
module lpg_chk
  import lpg_pkg::*;
#(
  parameter int W  = 16,
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          seed_ld,
  input logic          shift_en,
  input logic          reload,
  input logic [W-1:0]  gen_word,
  input logic [W-1:0]  fill_word,
  input logic [W-1:0]  mask_word,
  input logic [W-1:0]  stage_word,
  input logic [CH-1:0] chain_out
);

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    gen_word != '0); // R2

  AST_GEN_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !seed_ld) |=> gen_word[W-1:1] == $past(gen_word[W-2:0])); // R3

  AST_GEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !seed_ld) |=> $stable(gen_word)); // R3

  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stage_word)); // R5

  AST_FROZEN_STAGE: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ((stage_word ^ $past(stage_word)) & ~$past(mask_word)) == '0); // R5

  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    reload |=> mask_word == $past(fill_word)); // R8

  for (genvar c = 0; c < CH; c++) begin : g_frz
    localparam int unsigned IA = spread_tap(c, 0, W);
    localparam int unsigned IB = spread_tap(c, 1, W);
    localparam int unsigned IC = spread_tap(c, 2, W);
    AST_FROZEN_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (!mask_word[IA] && !mask_word[IB] && !mask_word[IC]) |-> ##2 $stable(chain_out[c])); // R9
  end

endmodule

bind lp_prpg lpg_chk #(.W(W), .CH(CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .seed_ld    (seed_ld),
  .shift_en   (shift_en),
  .reload     (reload),
  .gen_word   (gen_word),
  .fill_word  (fill_word),
  .mask_word  (mask_word),
  .stage_word (stage_word),
  .chain_out  (chain_out)
);

// File: tb/lp_prpg_tb.sv
`timescale 1ns/1ps
module lp_prpg_tb;
  localparam int W  = 16;
  localparam int CH = 8;
  localparam int S  = W / 3;
  localparam logic [W-1:0] TAPS = 16'hB400;
  localparam logic [W-1:0] DEF  = 16'hACE1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          seed_ld = 1'b0;
  logic [W-1:0]  seed_val = '0;
  logic          shift_en = 1'b0;
  logic          mask_bit = 1'b0;
  logic          mask_shift = 1'b0;
  logic          reload = 1'b0;
  logic [CH-1:0] chain_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lp_prpg #(.W(W), .CH(CH), .TAPS(TAPS), .DEF_SEED(DEF)) u_dut (
    .clk(clk), .rst(rst), .seed_ld(seed_ld), .seed_val(seed_val),
    .shift_en(shift_en), .mask_bit(mask_bit), .mask_shift(mask_shift),
    .reload(reload), .chain_out(chain_out)
  );

  // Reference model built from the requirements.
  logic [W-1:0]  m_gen, m_fill, m_mask, m_stage;
  logic [CH-1:0] m_chain;

  function automatic logic [W-1:0] step_gen(input logic [W-1:0] g);
    return {g[W-2:0], ^(g & TAPS)};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_gen <= DEF; m_fill <= '0; m_mask <= '1; m_stage <= '0; m_chain <= '0;
    end else begin
      if (seed_ld) m_gen <= (seed_val == '0) ? DEF : seed_val;
      else if (shift_en) m_gen <= step_gen(m_gen);
      if (mask_shift) m_fill <= {m_fill[W-2:0], mask_bit};
      if (reload) m_mask <= m_fill;
      if (shift_en) m_stage <= (m_stage & ~m_mask) | (m_gen & m_mask);
      for (int c = 0; c < CH; c++)
        m_chain[c] <= m_stage[c % W] ^ m_stage[(c + S) % W] ^ m_stage[(c + 2*S) % W];
    end
  end

  task automatic check_eq(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: chain_out=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock edge with current inputs, then compare against the model.
  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    check_eq(req, chain_out, m_chain);
  endtask

  task automatic load_fill(input logic [W-1:0] m, input string req);
    mask_shift = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      mask_bit = m[i];
      tick(req);
    end
    mask_shift = 1'b0;
    mask_bit = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", chain_out, '0);
    rst = 1'b0;
  endtask

  task automatic t_free_run();
    seed_val = 16'h1D2B; seed_ld = 1'b1;
    tick("R2");
    seed_ld = 1'b0; shift_en = 1'b1;
    for (int n = 0; n < 40; n++) tick("R3/R4/R6");
    shift_en = 1'b0;
  endtask

  task automatic t_idle();
    logic [CH-1:0] v;
    tick("R5");
    v = chain_out;
    for (int n = 0; n < 5; n++) begin
      tick("R3");
      check_eq("R5 idle", chain_out, v);
    end
  endtask

  task automatic t_zero_seed();
    seed_val = '0; seed_ld = 1'b1; shift_en = 1'b1;
    tick("R2 zero seed");
    seed_ld = 1'b0;
    for (int n = 0; n < 20; n++) tick("R2");
    seed_val = 16'h8001; seed_ld = 1'b1;
    tick("R2 priority");
    seed_ld = 1'b0;
    for (int n = 0; n < 20; n++) tick("R2");
    shift_en = 1'b0;
  endtask

  task automatic t_fill_reload();
    load_fill(16'h5A3C, "R7");
    reload = 1'b1; mask_shift = 1'b1; mask_bit = 1'b1;
    tick("R8 same edge");
    reload = 1'b0; mask_shift = 1'b0; mask_bit = 1'b0;
    shift_en = 1'b1;
    for (int n = 0; n < 30; n++) tick("R5/R8");
    shift_en = 1'b0;
  endtask

  task automatic t_frozen_chain();
    logic [W-1:0] m;
    logic         v0;
    m = '1;
    m[0] = 1'b0; m[S] = 1'b0; m[2*S] = 1'b0;
    load_fill(m, "R7");
    reload = 1'b1;
    tick("R8");
    reload = 1'b0; shift_en = 1'b1;
    tick("R9"); tick("R9");
    v0 = chain_out[0];
    for (int n = 0; n < 25; n++) begin
      tick("R9");
      checks++;
      if (chain_out[0] !== v0) begin
        errors++;
        $display("FAIL R9: chain0=%b expected=%b", chain_out[0], v0);
      end
    end
    shift_en = 1'b0;
  endtask

  task automatic t_all_hold();
    logic [CH-1:0] v;
    logic [CH-1:0] first;
    int            moved;
    load_fill('0, "R7");
    reload = 1'b1;
    tick("R10");
    reload = 1'b0; shift_en = 1'b1;
    tick("R10"); tick("R10");
    v = chain_out;
    for (int n = 0; n < 20; n++) begin
      tick("R10");
      check_eq("R10 frozen", chain_out, v);
    end
    load_fill('1, "R10");
    reload = 1'b1;
    tick("R10");
    reload = 1'b0;
    first = chain_out; moved = 0;
    for (int n = 0; n < 20; n++) begin
      tick("R10");
      if (chain_out !== first) moved = 1;
    end
    checks++;
    if (moved == 0) begin
      errors++;
      $display("FAIL R10: chain_out=%h expected=changing", chain_out);
    end
    shift_en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_free_run();
    t_idle();
    t_zero_seed();
    t_fill_reload();
    t_frozen_chain();
    t_all_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule